// File: doc/BRIEF.md
# Linear to Paged Address Translator

The block turns a linear byte address into the split address used by a serial flash whose pages may be 256, 512 or 1024 bytes, or 264, 528 or 1056 bytes when the device runs in its non-binary page mode. In the device address, the page number sits above an offset field. The offset field is just wide enough to hold the largest byte offset in a page. For non-binary pages this leaves unused codes between pages, so the translation needs a real division.

A request carries an address, a length, a page-size selection, a flag that says whether pages are binary, and an operation flag that asks for page alignment (erase and program) or not (read). The block pulses `done_o` when it has finished. At that point it either presents the 24-bit device address or raises `err_o` because the request runs past the end of the device or is misaligned. Binary page sizes are handled in one cycle. Non-binary sizes go through a shift-subtract divider that takes one cycle per address bit.

Top module: `paged_addr_xlate`

## Requirements
- R1: Page size follows `page_sel_i`: 0 selects 256, 1 selects 512, and 2 or 3 select 1024 bytes when `bin_page_i`=1. When `bin_page_i`=0 each of these grows by 33/32, giving 264, 528 and 1056.
- R2: When there is no error, `dev_addr_o` = ((addr / page) << W) | (addr mod page), taken over 24 bits. W is the least bit count that can hold page−1, so W is 8, 9, 10, 9, 10 or 11 for 256, 512, 1024, 264, 528 and 1056.
- R3: With binary pages, `done_o` is high in the cycle after the accepted start, and the device address equals the linear address.
- R4: With non-binary pages and a request in bounds, `done_o` rises no later than ADDR_W+2 cycles after the accepted start, and `busy_o` stays high until then.
- R5: A request with addr+len greater than NUM_PAGES×page sets `err_o` together with `done_o` in the cycle after start, for either operation.
- R6: With `op_align_i`=1, an address or length that is not a whole multiple of the page size sets `err_o` together with `done_o`.
- R7: With `op_align_i`=0, an unaligned address or length in bounds gives no error and is translated.
- R8: `done_o` is a single-cycle pulse, and `err_o` is never high without `done_o`.
- R9: A `start_i` that arrives while `busy_o` is high is ignored: the result reflects the request already in progress.
- R10: After reset, `done_o`, `err_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted while not busy |
| addr_i | input | ADDR_W | Linear byte address |
| len_i | input | ADDR_W | Byte count of the access |
| op_align_i | input | 1 | 1: page alignment is required (erase/program) |
| page_sel_i | input | 2 | Base page size code |
| bin_page_i | input | 1 | 1: binary page size, 0: 33/32 scaled |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected, valid with done_o |
| dev_addr_o | output | ADDR_W | Paged device address |

## Verification
Random requests mix all six page sizes with both operation kinds. Their addresses fall on page boundaries, inside pages, or beyond the device end, so that quotient, remainder and offset width are all checked against a bench model. Directed cases follow:
- The last page of the largest non-binary geometry, which exercises the top quotient bits.
- A request that ends exactly at the device size, next to one that overshoots it by a single byte, which separates `>` from `>=`.
- An aligned address paired with an unaligned length, which separates the two alignment checks.
- A second strobe sent in the middle of a division, which shows whether a busy request can be disturbed.

// File: rtl/paged_xlate_pkg.sv
package paged_xlate_pkg;
  localparam int unsigned PAGE_W = 11;  // holds the widest page (1056)
  localparam int unsigned OFFW_W = 4;

  function automatic logic [PAGE_W-1:0] page_bytes(input logic [1:0] sel, input logic bin);
    logic [PAGE_W-1:0] base;
    base = (sel == 2'd0) ? PAGE_W'(256) : (sel == 2'd1) ? PAGE_W'(512) : PAGE_W'(1024);
    return bin ? base : base + (base >> 5);
  endfunction

  function automatic logic [OFFW_W-1:0] offset_bits(input logic [PAGE_W-1:0] ps);
    logic [PAGE_W-1:0] lim;
    logic [OFFW_W-1:0] w;
    lim = ps - 1'b1;
    w = '0;
    for (int i = 0; i < PAGE_W; i++)
      if (lim[i]) w = OFFW_W'(i + 1);
    return w;
  endfunction
endpackage

// File: rtl/paged_geom.sv
module paged_geom
  import paged_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned NUM_PAGES = 4096
) (
  input  logic [1:0]        page_sel_i,
  input  logic              bin_page_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFFW_W-1:0] offw_o,
  output logic [ADDR_W:0]   total_o
);
  always_comb begin
    page_o  = page_bytes(page_sel_i, bin_page_i);
    offw_o  = offset_bits(page_o);
    total_o = (ADDR_W+1)'(NUM_PAGES) * (ADDR_W+1)'(page_o);
  end
endmodule

// File: rtl/paged_divider.sv
module paged_divider #(
  parameter int unsigned N_W = 24,
  parameter int unsigned D_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic           valid_o,
  output logic [N_W-1:0] quo_o,
  output logic [D_W-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(N_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [N_W-1:0]   quo_q;
  logic [D_W-1:0]   rem_q, den_q;
  logic [D_W:0]     trial;
  logic             fits;

  always_comb begin
    trial = {rem_q, quo_q[N_W-1]};
    fits  = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        cnt_q <= CNT_W'(N_W);
        quo_q <= num_i;
        rem_q <= '0;
        den_q <= den_i;
      end else if (cnt_q != '0) begin
        cnt_q   <= cnt_q - 1'b1;
        quo_q   <= {quo_q[N_W-2:0], fits};
        rem_q   <= fits ? D_W'(trial - {1'b0, den_q}) : trial[D_W-1:0];
        valid_o <= (cnt_q == CNT_W'(1));
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // restoring step keeps the partial remainder below the divisor (R2)
  assert_rem_below_den_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rem_q < den_q));
  assert_count_steps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/paged_addr_xlate.sv
module paged_addr_xlate
  import paged_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned NUM_PAGES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic              op_align_i,
  input  logic [1:0]        page_sel_i,
  input  logic              bin_page_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] dev_addr_o
);
  logic [PAGE_W-1:0] page;
  logic [OFFW_W-1:0] offw;
  logic [ADDR_W:0]   total;
  logic              accept, over, bin_bad, div_go;
  logic              busy_q, done_q, err_q, op_q;
  logic [OFFW_W-1:0] offw_q;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] dev_q;

  logic              va_valid, vl_valid;
  logic [ADDR_W-1:0] a_quo, l_quo;
  logic [PAGE_W-1:0] a_rem, l_rem;

  paged_geom #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) i_geom (
    .page_sel_i(page_sel_i), .bin_page_i(bin_page_i),
    .page_o(page), .offw_o(offw), .total_o(total)
  );

  always_comb begin
    accept  = start_i && !busy_q;
    over    = ({1'b0, addr_i} + {1'b0, len_i}) > total;
    bin_bad = op_align_i && ((addr_i | len_i) & ADDR_W'(page - 1'b1)) != '0;
    div_go  = accept && !over && !bin_page_i;
  end

  // address and length are divided side by side
  paged_divider #(.N_W(ADDR_W), .D_W(PAGE_W)) i_div_addr (
    .clk_i, .rst_ni, .start_i(div_go), .num_i(addr_i), .den_i(page),
    .valid_o(va_valid), .quo_o(a_quo), .rem_o(a_rem)
  );
  paged_divider #(.N_W(ADDR_W), .D_W(PAGE_W)) i_div_len (
    .clk_i, .rst_ni, .start_i(div_go), .num_i(len_i), .den_i(page),
    .valid_o(vl_valid), .quo_o(l_quo), .rem_o(l_rem)
  );

  logic unused_len_quo;
  assign unused_len_quo = ^l_quo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= 1'b0;
      offw_q <= '0;
      page_q <= '0;
      dev_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        op_q   <= op_align_i;
        offw_q <= offw;
        page_q <= page;
        if (over) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else if (bin_page_i) begin
          done_q <= 1'b1;
          err_q  <= bin_bad;
          dev_q  <= addr_i;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q && va_valid) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= op_q && (a_rem != '0 || l_rem != '0);
        dev_q  <= ADDR_W'(a_quo << offw_q) | ADDR_W'(a_rem);
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign dev_addr_o = dev_q;

  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_bin_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bin_page_i) |=> (done_o && !busy_o));
  assert_dividers_agree_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    va_valid |-> vl_valid);
  assert_offset_in_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ((dev_addr_o & ((ADDR_W'(1) << offw_q) - 1'b1)) < ADDR_W'(page_q)));
  assert_busy_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !va_valid) |=> busy_o);
endmodule

// File: tb/test_paged_addr_xlate.sv
module test_paged_addr_xlate;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned NUM_PAGES = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0, bin = 1'b1;
  logic [1:0] sel = '0;
  logic [ADDR_W-1:0] addr = '0, len = '0;
  logic busy, done, err;
  logic [ADDR_W-1:0] dev;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_addr_xlate #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) i_paged_addr_xlate (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .op_align_i(op), .page_sel_i(sel), .bin_page_i(bin),
    .busy_o(busy), .done_o(done), .err_o(err), .dev_addr_o(dev)
  );

  function automatic longint pg(input logic [1:0] s, input logic b);
    longint base = (s == 0) ? 256 : (s == 1) ? 512 : 1024;
    return b ? base : base * 33 / 32;
  endfunction

  function automatic int offw(input longint p);
    int w = 0;
    for (int i = 0; i < 16; i++) if (((p - 1) >> i) != 0) w = i + 1;
    return w;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input longint a, input longint l, input logic o,
                     input logic [1:0] s, input logic b, input bit disturb);
    longint p = pg(s, b);
    longint total = p * NUM_PAGES;
    bit e_over = (a + l) > total;
    bit e_mis = o && ((a % p) != 0 || (l % p) != 0);
    longint e_dev = (((a / p) << offw(p)) | (a % p)) & 24'hFFFFFF;
    int cyc = 0;
    @(negedge clk);
    addr = ADDR_W'(a); len = ADDR_W'(l); op = o; sel = s; bin = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      if (disturb && cyc == 3) begin
        chk("R9 busy during division", busy, 1);
        addr = ADDR_W'(a + p + 1); op = 1'b1; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk("R8 done seen", done, 1);
    if (e_over || b) chk("R3/R5 one-cycle latency", cyc, 1);
    else chk("R4 latency bound", (cyc <= ADDR_W + 2), 1);
    chk(e_over ? "R5 bound error" : (o ? "R6 alignment error" : "R7 no error on read"),
        err, e_over || e_mis);
    if (!(e_over || e_mis)) chk(b ? "R3 binary passthrough" : "R2 device address", dev, e_dev);
    @(negedge clk);
    chk("R8 done pulse", done, 0);
    chk("R8 err only with done", err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails + 1 - 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    chk("R10 reset done", done, 0);
    chk("R10 reset err", err, 0);
    chk("R10 reset busy", busy, 0);
    rst_n = 1'b1;

    // R1/R2 directed geometries: page 5 offset 7 in each size
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++)
        run(pg(2'(s), 1'(b)) * 5 + 7, 1, 1'b0, 2'(s), 1'(b), 0);
    // last page of largest non-binary geometry
    run(1056 * (NUM_PAGES - 1), 1056, 1'b1, 2'd2, 1'b0, 0);
    // R5 exact end vs one past
    run(1056 * NUM_PAGES - 16, 16, 1'b0, 2'd2, 1'b0, 0);
    run(1056 * NUM_PAGES - 16, 17, 1'b0, 2'd2, 1'b0, 0);
    run(256 * NUM_PAGES, 1, 1'b0, 2'd0, 1'b1, 0);
    // R6 aligned address, unaligned length; unaligned address
    run(528 * 9, 527, 1'b1, 2'd1, 1'b0, 0);
    run(528 * 9 + 1, 528, 1'b1, 2'd1, 1'b0, 0);
    run(512 * 9, 100, 1'b1, 2'd1, 1'b1, 0);
    // R7 unaligned read
    run(264 * 3 + 100, 33, 1'b0, 2'd0, 1'b0, 0);
    // R9 strobe during busy
    run(264 * 40 + 3, 264, 1'b0, 2'd0, 1'b0, 1);

    for (int i = 0; i < 60; i++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic b = 1'($urandom_range(0, 1));
      longint p = pg(s, b);
      longint total = p * NUM_PAGES;
      int kind = $urandom_range(0, 3);
      longint a, l;
      case (kind)
        0: begin a = p * $urandom_range(0, NUM_PAGES - 4); l = p * $urandom_range(1, 3); end
        1: begin a = $urandom_range(0, 32'(total - 600)); l = $urandom_range(1, 500); end
        2: begin a = total - $urandom_range(0, 40); l = $urandom_range(1, 80); end
        default: begin a = p * $urandom_range(0, NUM_PAGES - 2); l = $urandom_range(1, 32'(2 * p)); end
      endcase
      run(a, l, 1'($urandom_range(0, 1)), s, b, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule